// File: doc/BRIEF.md
# Data Parity Error Reporter

This block monitors a shared, multiplexed address/data bus and checks even parity on every data phase. The 32 data lines and the 4 command/byte-enable lines of a valid data phase are reduced to one parity bit and held for one clock. The parity bit for that phase arrives on the following clock and is compared with the held value. A mismatch is an error.

When the error is one this agent must report, the block pulls an active-low error line low in the clock after the parity bit, which is two clocks after the faulty data. The line is driven through an output-enable, because the real pad is a shared three-state net with a weak pull-up. Errors in consecutive data phases keep the line low without a gap. After the last error the block drives the line high for exactly one clock and then releases it. Whether an error is reported depends on the direction of the transfer and on this agent's role in it. Special cycles are never reported, and a report-enable input can suppress reporting altogether. A sticky flag records that at least one error has been reported. Software clears it with a one-clock clear pulse.

Top module: `dpar_err_reporter`

## Requirements
- R1: Parity is even. A valid data phase is in error when the XOR of `ad_i` (32 bits) and `cbe_i` (4 bits), both sampled with `data_valid_i`, and of `par_i`, sampled one clock later, is 1. The value of `par_i` in any other clock is ignored.
- R2: For a reported error whose data is sampled at clock edge N, `perr_n_o` is 0 and `perr_oe_o` is 1 in the clock that follows edge N+1.
- R3: On a write (`write_i`=1), an error is reported only when `target_claimed_i`=1. A write with `master_i`=1 and `target_claimed_i`=0 leaves `perr_n_o`=1 and `perr_oe_o`=0.
- R4: On a read (`write_i`=0), an error is reported only when `master_i`=1. A read with `master_i`=0 leaves the outputs idle.
- R5: A data phase with `special_cycle_i`=1 is never reported.
- R6: With `report_en_i`=0 no error is reported and the sticky flag is not set.
- R7: Reported errors in consecutive data phases hold `perr_n_o` low for one clock per erroneous phase, with no high clock between them.
- R8: After the last low clock, `perr_n_o`=1 with `perr_oe_o`=1 for exactly one clock. The clock after that, `perr_oe_o`=0. `perr_oe_o` never falls while `perr_n_o` is low. A new error during the high clock drives the line low again.
- R9: While `perr_oe_o`=0, `perr_n_o` reads 1, which is the pulled-up released level. After reset, `perr_n_o`=1, `perr_oe_o`=0 and `err_sticky_o`=0.
- R10: `err_sticky_o` becomes 1 on the same edge that a reported error drives the line low. It stays 1 until an edge where `sticky_clr_i`=1 and no new error is reported. A new error on the same edge as a clear wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_valid_i | input | 1 | A data phase is on the bus in this clock |
| ad_i | input | 32 | Address/data lines |
| cbe_i | input | 4 | Command/byte-enable lines |
| par_i | input | 1 | Even parity bit, one clock after its data |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| master_i | input | 1 | This agent is the initiator of the transfer |
| target_claimed_i | input | 1 | This agent claimed the transfer as target |
| special_cycle_i | input | 1 | The transfer is a special cycle |
| report_en_i | input | 1 | Enables error reporting |
| sticky_clr_i | input | 1 | Clear pulse for the sticky flag |
| perr_n_o | output | 1 | Data parity error, active low |
| perr_oe_o | output | 1 | Output-enable for the error line pad |
| err_sticky_o | output | 1 | Sticky record of a reported error |

## Verification
The block holds internal state in three places: the held phase parity and eligibility, the drive state of the error line, and the sticky flag. A wrong held parity or eligibility bit shows at the ports as a missing or spurious low on `perr_n_o`, in the clock that follows the parity bit. A wrong drive state shows within one or two clocks. It appears as a high gap between back-to-back errors, as a missing one-clock high drive, or as the line released straight from low. A wrong sticky update shows on `err_sticky_o` on the same edge as the error, or on the edge after a clear pulse.

// File: rtl/dperr_pkg.sv
package dperr_pkg;
  typedef enum logic [1:0] {
    DRV_IDLE = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_HIGH = 2'd2
  } drv_state_e;
endpackage

// File: rtl/dperr_parity_tree.sv
module dperr_parity_tree #(
  parameter int W   = 36,
  parameter int GRP = 4
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);
  localparam int NG    = (W + GRP - 1) / GRP;
  localparam int PAD_W = NG * GRP;

  logic [PAD_W-1:0] padded;
  logic [NG-1:0]    part;

  assign padded = PAD_W'(data_i);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign part[g] = ^padded[g*GRP +: GRP];
  end

  assign par_o = ^part;
endmodule

// File: rtl/dperr_phase_capture.sv
module dperr_phase_capture #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_i,
  input  logic              par_i,
  input  logic              write_i,
  input  logic              master_i,
  input  logic              target_claimed_i,
  input  logic              special_cycle_i,
  input  logic              report_en_i,
  output logic              err_o
);
  localparam int CHK_W = DATA_W + CBE_W;

  logic phase_par;
  logic eligible;
  logic ph_valid_q, ph_par_q, ph_elig_q;

  dperr_parity_tree #(.W(CHK_W)) i_tree (
    .data_i ({ad_i, cbe_i}),
    .par_o  (phase_par)
  );

  // write: claimed target reports; read: master reports
  always_comb begin
    eligible = report_en_i && !special_cycle_i &&
               (write_i ? target_claimed_i : master_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_valid_q <= 1'b0;
      ph_par_q   <= 1'b0;
      ph_elig_q  <= 1'b0;
    end else begin
      ph_valid_q <= data_valid_i;
      ph_par_q   <= data_valid_i ? phase_par : 1'b0;
      ph_elig_q  <= data_valid_i && eligible;
    end
  end

  assign err_o = ph_valid_q && ph_elig_q && (ph_par_q ^ par_i);
endmodule

// File: rtl/dperr_line_drive.sv
module dperr_line_drive
  import dperr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  output logic perr_n_o,
  output logic perr_oe_o
);
  drv_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DRV_IDLE: if (err_i) state_d = DRV_LOW;
      DRV_LOW:  state_d = err_i ? DRV_LOW : DRV_HIGH;
      DRV_HIGH: state_d = err_i ? DRV_LOW : DRV_IDLE;
      default:  state_d = DRV_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DRV_IDLE;
    else         state_q <= state_d;
  end

  assign perr_n_o  = (state_q != DRV_LOW);
  assign perr_oe_o = (state_q != DRV_IDLE);
endmodule

// File: rtl/dpar_err_reporter.sv
module dpar_err_reporter #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_i,
  input  logic              par_i,
  input  logic              write_i,
  input  logic              master_i,
  input  logic              target_claimed_i,
  input  logic              special_cycle_i,
  input  logic              report_en_i,
  input  logic              sticky_clr_i,
  output logic              perr_n_o,
  output logic              perr_oe_o,
  output logic              err_sticky_o
);
  logic err;
  logic sticky_q;

  dperr_phase_capture #(.DATA_W(DATA_W), .CBE_W(CBE_W)) i_capture (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .data_valid_i     (data_valid_i),
    .ad_i             (ad_i),
    .cbe_i            (cbe_i),
    .par_i            (par_i),
    .write_i          (write_i),
    .master_i         (master_i),
    .target_claimed_i (target_claimed_i),
    .special_cycle_i  (special_cycle_i),
    .report_en_i      (report_en_i),
    .err_o            (err)
  );

  dperr_line_drive i_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_i     (err),
    .perr_n_o  (perr_n_o),
    .perr_oe_o (perr_oe_o)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sticky_q <= 1'b0;
    else if (err)          sticky_q <= 1'b1;
    else if (sticky_clr_i) sticky_q <= 1'b0;
  end

  assign err_sticky_o = sticky_q;
endmodule

// File: rtl/dpar_err_reporter_chk.sv
module dpar_err_reporter_chk #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              data_valid_i,
  input logic [DATA_W-1:0] ad_i,
  input logic [CBE_W-1:0]  cbe_i,
  input logic              par_i,
  input logic              write_i,
  input logic              master_i,
  input logic              target_claimed_i,
  input logic              special_cycle_i,
  input logic              report_en_i,
  input logic              perr_n_o,
  input logic              perr_oe_o,
  input logic              err_sticky_o
);
  logic rep_phase;
  assign rep_phase = data_valid_i && report_en_i && !special_cycle_i &&
                     (write_i ? target_claimed_i : master_i);

  // R2: a reportable mismatch drives the line low one clock after parity
  assert_err_timing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rep_phase) && (^{$past(ad_i), $past(cbe_i), par_i})) |=> !perr_n_o);

  // R2 R3 R4 R5: a low edge needs a reportable phase two clocks earlier
  assert_low_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(perr_n_o) |-> $past(rep_phase, 2));

  // R8: never released straight from low
  assert_no_release_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_oe_o && !perr_n_o) |=> perr_oe_o);

  assert_high_before_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(perr_oe_o) |-> $past(perr_n_o));

  // R9
  assert_released_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_oe_o |-> perr_n_o);

  // R10
  assert_sticky_on_error_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_sticky_o) |-> !perr_n_o);
endmodule

bind dpar_err_reporter dpar_err_reporter_chk #(.DATA_W(DATA_W), .CBE_W(CBE_W)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .data_valid_i     (data_valid_i),
  .ad_i             (ad_i),
  .cbe_i            (cbe_i),
  .par_i            (par_i),
  .write_i          (write_i),
  .master_i         (master_i),
  .target_claimed_i (target_claimed_i),
  .special_cycle_i  (special_cycle_i),
  .report_en_i      (report_en_i),
  .perr_n_o         (perr_n_o),
  .perr_oe_o        (perr_oe_o),
  .err_sticky_o     (err_sticky_o)
);

// File: tb/test_dpar_err_reporter.sv
module test_dpar_err_reporter;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        data_valid_i, par_i, write_i, master_i, target_claimed_i;
  logic        special_cycle_i, report_en_i, sticky_clr_i;
  logic [31:0] ad_i;
  logic [3:0]  cbe_i;
  logic        perr_n_o, perr_oe_o, err_sticky_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;

  dpar_err_reporter i_dpar_err_reporter (.*);

  typedef struct packed {
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        bad, wr, mst, clm, spc, en, exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1}, // R1 good
    '{32'hDEAD_BEEF, 4'h7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3}, // R3 target wr
    '{32'h1234_5678, 4'h3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 master wr
    '{32'hA5A5_0F0F, 4'hC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 master rd
    '{32'h0BAD_F00D, 4'h2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 target rd
    '{32'h5555_AAAA, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5}, // R5 special
    '{32'hCAFE_0001, 4'h9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5}, // R5 special
    '{32'h7777_7777, 4'h4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 disabled
    '{32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1}, // R1 good
    '{32'h0000_0001, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1}, // R1 bad
    '{32'h8000_0001, 4'h8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1}, // R1 good
    '{32'h0000_0000, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2}  // R2 bad
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic epar(input logic [31:0] a, input logic [3:0] c, input logic bad);
    return (^{a, c}) ^ bad;
  endfunction

  // drive one data-bus cycle at the current negedge
  task automatic bus(input logic v, input logic [31:0] a, input logic [3:0] c, input logic p);
    data_valid_i = v; ad_i = a; cbe_i = c; par_i = p;
  endtask

  task automatic role(input logic wr, input logic mst, input logic clm,
                      input logic spc, input logic en);
    write_i = wr; master_i = mst; target_claimed_i = clm;
    special_cycle_i = spc; report_en_i = en;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog R2 act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    bus(1'b0, 32'h0, 4'h0, 1'b0);
    role(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sticky_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 reset perr_n", 32'(perr_n_o), 1);
    chk("R9 reset oe", 32'(perr_oe_o), 0);
    chk("R9 reset sticky", 32'(err_sticky_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: isolated phases
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      role(VECS[i].wr, VECS[i].mst, VECS[i].clm, VECS[i].spc, VECS[i].en);
      bus(1'b1, VECS[i].ad, VECS[i].cbe, ~epar(VECS[i].ad, VECS[i].cbe, VECS[i].bad));
      @(negedge clk_i);
      // bus value now junk; only the held phase counts
      bus(1'b0, ~VECS[i].ad, VECS[i].cbe, epar(VECS[i].ad, VECS[i].cbe, VECS[i].bad));
      @(negedge clk_i);
      bus(1'b0, 32'h0, 4'h0, 1'b1);
      chk({tg, " low"}, 32'(perr_n_o), 32'(!VECS[i].exp));
      chk({tg, " oe"}, 32'(perr_oe_o), 32'(VECS[i].exp));
      chk({tg, " R10 sticky"}, 32'(err_sticky_o), 32'(VECS[i].exp));
      @(negedge clk_i);
      chk({tg, " R8 high"}, 32'(perr_n_o), 1);
      chk({tg, " R8 oe"}, 32'(perr_oe_o), 32'(VECS[i].exp));
      @(negedge clk_i);
      chk({tg, " R8 released"}, 32'(perr_oe_o), 0);
      chk({tg, " R9 level"}, 32'(perr_n_o), 1);
      sticky_clr_i = 1'b1;
      @(negedge clk_i);
      sticky_clr_i = 1'b0;
      chk({tg, " R10 cleared"}, 32'(err_sticky_o), 0);
    end

    // R7: back-to-back bad, bad, good on a claimed write
    role(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    bus(1'b1, 32'h1111_0000, 4'h6, 1'b0);
    @(negedge clk_i);
    bus(1'b1, 32'h2222_0000, 4'h5, epar(32'h1111_0000, 4'h6, 1'b1));
    @(negedge clk_i);
    bus(1'b1, 32'h3333_0001, 4'h0, epar(32'h2222_0000, 4'h5, 1'b1));
    chk("R7 b2b first low", 32'(perr_n_o), 0);
    @(negedge clk_i);
    bus(1'b0, 32'h0, 4'h0, epar(32'h3333_0001, 4'h0, 1'b0));
    chk("R7 b2b second low", 32'(perr_n_o), 0);
    @(negedge clk_i);
    bus(1'b0, 32'h0, 4'h0, 1'b0);
    chk("R8 b2b high", 32'(perr_n_o), 1);
    chk("R8 b2b high oe", 32'(perr_oe_o), 1);
    @(negedge clk_i);
    chk("R8 b2b released", 32'(perr_oe_o), 0);

    // R8: new error during the high clock drives low again
    bus(1'b1, 32'h0000_00F1, 4'h0, 1'b0);
    @(negedge clk_i);
    bus(1'b0, 32'h0, 4'h0, epar(32'h0000_00F1, 4'h0, 1'b1));
    @(negedge clk_i);
    bus(1'b1, 32'h0000_00F2, 4'h0, 1'b0);
    chk("R2 gap first low", 32'(perr_n_o), 0);
    @(negedge clk_i);
    bus(1'b0, 32'h0, 4'h0, epar(32'h0000_00F2, 4'h0, 1'b1));
    chk("R8 gap high", 32'(perr_n_o), 1);
    chk("R8 gap high oe", 32'(perr_oe_o), 1);
    @(negedge clk_i);
    bus(1'b0, 32'h0, 4'h0, 1'b0);
    chk("R8 gap low again", 32'(perr_n_o), 0);
    @(negedge clk_i);
    chk("R8 gap high2", 32'(perr_n_o), 1);
    chk("R8 gap oe2", 32'(perr_oe_o), 1);
    @(negedge clk_i);
    chk("R8 gap released", 32'(perr_oe_o), 0);

    // R10: clear on the same edge as a new error, set wins
    sticky_clr_i = 1'b1;
    @(negedge clk_i);
    sticky_clr_i = 1'b0;
    chk("R10 pre clear", 32'(err_sticky_o), 0);
    bus(1'b1, 32'h0000_0003, 4'h0, 1'b0);
    @(negedge clk_i);
    bus(1'b0, 32'h0, 4'h0, epar(32'h0000_0003, 4'h0, 1'b1));
    sticky_clr_i = 1'b1;
    @(negedge clk_i);
    sticky_clr_i = 1'b0;
    bus(1'b0, 32'h0, 4'h0, 1'b0);
    chk("R10 set wins", 32'(err_sticky_o), 1);
    repeat (2) @(negedge clk_i);
    chk("R10 held", 32'(err_sticky_o), 1);

    // R1: parity outside a phase is ignored
    bus(1'b0, 32'h0, 4'h0, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R1 stray parity", 32'(perr_oe_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule